// File: doc/BRIEF.md
# Interrupt Status Unit with Level and Message Signalling

This block holds a 32-bit word of pending interrupt causes for a small register-mapped device. Software sets cause bits by writing a value to a set-register, and it clears them by writing a value to a clear-register. The word is read back through a read-only status register. A compute engine can also set a cause bit when it reports that a calculation has finished. This happens only while software has armed that source through a bit in the control register.

Two signalling modes are available, and an input chooses between them. In level mode a single interrupt line rises when a cause is set and falls when a clear leaves the word empty. In message mode every set that leaves the word nonzero produces a registered request pulse that lasts one clock. In this mode a clear never touches the level line, but software must still clear the cause bits. Level mode applies whenever the mode input is low, which is also the state after reset.

Register offsets: control at 0x20, status at 0x24, set at 0x60, clear at 0x64.

Top module: `irqstat_unit`

## Requirements
- R1: A write of V to offset 0x60 makes the status word (at offset 0x24) old OR V on the next clock.
- R2: A write of V to offset 0x64 makes the status word old AND NOT V on the next clock.
- R3: With `msi_en` low, any set (software or completion) that leaves the status word nonzero drives `intx_o` high on the next clock.
- R4: With `msi_en` low, `intx_o` falls only after a clear that leaves the status word zero, and otherwise holds its value.
- R5: With `msi_en` high, each set that leaves the status word nonzero gives `msi_req_o` high for exactly the following clock. No other event raises `msi_req_o`.
- R6: While `msi_en` is high, `intx_o` keeps its value on every cycle, including cycles with clears.
- R7: Control register at offset 0x20: bit 7 is a read/write completion enable. Bit 0 is read-only and reads 1 from the clock after a `calc_start` pulse until the clock after a `calc_done` pulse. All other bits read 0.
- R8: A `calc_done` pulse while bit 7 is set acts as a set with value 0x00000001 and clears bit 0 in the same clock. With bit 7 clear, it leaves the status word unchanged.
- R9: A completion set and a software clear in the same cycle give the status word (old OR 1) AND NOT clear-value.
- R10: After reset the status word is 0, the control register reads 0, `intx_o` is low and `msi_req_o` is low.
- R11: Offsets 0x60 and 0x64 read as 0, and writes to offset 0x24 do not change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write value |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read value (combinational) |
| calc_start | input | 1 | Compute engine began a calculation |
| calc_done | input | 1 | Compute engine finished a calculation |
| msi_en | input | 1 | 1 selects message pulses, 0 selects level line |
| intx_o | output | 1 | Level interrupt line |
| msi_req_o | output | 1 | One-clock message request pulse |

## Verification
A completion set and a software clear can both occur in the same cycle, and they meet on the same status bits. The bench provokes this by pulsing `calc_done` with the enable set while it writes the clear register. It does so with clear values that include and exclude bit 0, in both signalling modes. The result is judged against (old OR 1) AND NOT clear-value, and against the level or pulse output that this result implies. A long pseudo-random mix of sets, clears, starts and completions repeats this against a bench model.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_SET   = 3'd3,
    SEL_CLR   = 3'd4
  } reg_sel_e;

  localparam int unsigned OFS_CTRL = 32'h20;
  localparam int unsigned OFS_STAT = 32'h24;
  localparam int unsigned OFS_SET  = 32'h60;
  localparam int unsigned OFS_CLR  = 32'h64;

  localparam int unsigned BIT_BUSY = 0;
  localparam int unsigned BIT_ARM  = 7;

endpackage

// File: rtl/irqstat_decode.sv
module irqstat_decode
  import irqstat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output reg_sel_e          wr_sel,
  output reg_sel_e          rd_sel
);

  function automatic reg_sel_e map_offset(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a == ADDR_W'(OFS_CTRL)) s = SEL_CTRL;
    if (a == ADDR_W'(OFS_STAT)) s = SEL_STAT;
    if (a == ADDR_W'(OFS_SET))  s = SEL_SET;
    if (a == ADDR_W'(OFS_CLR))  s = SEL_CLR;
    return s;
  endfunction

  always_comb begin
    wr_sel = wr_en ? map_offset(wr_addr) : SEL_NONE;
    rd_sel = map_offset(rd_addr);
  end

endmodule

// File: rtl/irqstat_ctrl.sv
module irqstat_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic arm_wdata,
  input  logic calc_start,
  input  logic calc_done,
  output logic arm_q,
  output logic busy_q,
  output logic done_set
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (ctrl_wr) arm_q <= arm_wdata;
      if (calc_start)     busy_q <= 1'b1;
      else if (calc_done) busy_q <= 1'b0;
    end
  end

  assign done_set = calc_done && arm_q;

endmodule

// File: rtl/irqstat_core.sv
module irqstat_core #(
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] DONE_VAL = 32'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_set,
  input  logic              msi_en,
  output logic [DATA_W-1:0] status_q,
  output logic              intx_q,
  output logic              msi_q,
  output logic              raise_ev
);

  function automatic logic [DATA_W-1:0] next_word(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] set_w,
    input logic [DATA_W-1:0] clr_w);
    return (old_w | set_w) & ~clr_w;
  endfunction

  logic [DATA_W-1:0] set_val, clr_val, nxt;
  logic              nxt_nz;

  always_comb begin
    set_val  = (set_wr ? wdata : '0) | (done_set ? DONE_VAL[DATA_W-1:0] : '0);
    clr_val  = clr_wr ? wdata : '0;
    nxt      = next_word(status_q, set_val, clr_val);
    nxt_nz   = |nxt;
    raise_ev = set_wr || done_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      intx_q   <= 1'b0;
      msi_q    <= 1'b0;
    end else begin
      status_q <= nxt;
      msi_q    <= raise_ev && nxt_nz && msi_en;
      if (!msi_en) begin
        if (raise_ev && nxt_nz)      intx_q <= 1'b1;
        else if (clr_wr && !nxt_nz)  intx_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqstat_unit.sv
module irqstat_unit
  import irqstat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              calc_start,
  input  logic              calc_done,
  input  logic              msi_en,
  output logic              intx_o,
  output logic              msi_req_o
);

  reg_sel_e          wr_sel, rd_sel;
  logic              set_wr, clr_wr, ctrl_wr;
  logic              arm_q, busy_q, done_set, raise_ev;
  logic [DATA_W-1:0] status_q;

  irqstat_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  assign set_wr  = (wr_sel == SEL_SET);
  assign clr_wr  = (wr_sel == SEL_CLR);
  assign ctrl_wr = (wr_sel == SEL_CTRL);

  irqstat_ctrl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .arm_wdata(wr_data[BIT_ARM]),
    .calc_start(calc_start), .calc_done(calc_done),
    .arm_q(arm_q), .busy_q(busy_q), .done_set(done_set)
  );

  irqstat_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .clr_wr(clr_wr),
    .wdata(wr_data), .done_set(done_set), .msi_en(msi_en),
    .status_q(status_q), .intx_q(intx_o), .msi_q(msi_req_o), .raise_ev(raise_ev)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: begin
        rd_data[BIT_ARM]  = arm_q;
        rd_data[BIT_BUSY] = busy_q;
      end
      SEL_STAT: rd_data = status_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/irqstat_chk.sv
module irqstat_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_en,
  input logic              intx,
  input logic              msi_req,
  input logic              raise_ev,
  input logic              set_wr,
  input logic              clr_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] status
);

  AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && !clr_wr) |=> ((status & $past(wr_data)) == $past(wr_data))); // R1

  AST_CLR_EMPTIES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((status & $past(wr_data)) == '0)); // R2

  AST_LEVEL_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_ev && !msi_en) |=> (intx || status == '0)); // R3

  AST_LEVEL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en && !raise_ev && !clr_wr) |=> $stable(intx)); // R4

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> ($past(msi_en) && $past(raise_ev))); // R5

  AST_LEVEL_FROZEN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |=> $stable(intx)); // R6

endmodule

bind irqstat_unit irqstat_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .intx(intx_o), .msi_req(msi_req_o),
  .raise_ev(raise_ev), .set_wr(set_wr), .clr_wr(clr_wr),
  .wr_data(wr_data), .status(status_q)
);

// File: tb/irqstat_unit_tb_top.sv
module irqstat_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        calc_start, calc_done, msi_en;
  logic        intx_o, msi_req_o;

  int n_vec = 0;
  int n_bad = 0;

  // bench model
  logic [31:0] m_stat;
  logic        m_arm, m_busy, m_intx, m_msi;

  always #4 clk = ~clk;

  irqstat_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .calc_start(calc_start),
    .calc_done(calc_done), .msi_en(msi_en), .intx_o(intx_o), .msi_req_o(msi_req_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "intx", {31'b0, intx_o}, {31'b0, m_intx});
    chk(tag, "msi", {31'b0, msi_req_o}, {31'b0, m_msi});
    rd_addr = 8'h24; #1;
    chk(tag, "status", rd_data, m_stat);
    rd_addr = 8'h20; #1;
    chk(tag, "ctrl", rd_data, {24'b0, m_arm, 6'b0, m_busy});
    rd_addr = 8'h60; #1;
    chk(tag, "set-read", rd_data, 32'h0);
    rd_addr = 8'h64; #1;
    chk(tag, "clr-read", rd_data, 32'h0);
  endtask

  // one clock: drive at negedge, update model, check after the edge
  task automatic step(input string tag, input logic we, input logic [7:0] a,
                      input logic [31:0] d, input logic st, input logic dn, input logic me);
    logic [31:0] sv, cv, nx;
    logic        rev, clrw;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    calc_start = st; calc_done = dn; msi_en = me;
    sv   = 32'h0;
    cv   = 32'h0;
    rev  = 1'b0;
    clrw = we && (a == 8'h64);
    if (we && a == 8'h60) begin sv = d; rev = 1'b1; end
    if (dn && m_arm)      begin sv = sv | 32'h1; rev = 1'b1; end
    if (clrw) cv = d;
    nx = m_stat;
    for (int b = 0; b < 32; b++) begin
      if (sv[b]) nx[b] = 1'b1;
      if (cv[b]) nx[b] = 1'b0;
    end
    m_msi = me && rev && (nx != 0);
    if (!me) begin
      if (rev && nx != 0)       m_intx = 1'b1;
      else if (clrw && nx == 0) m_intx = 1'b0;
    end
    m_stat = nx;
    if (we && a == 8'h20) m_arm = d[7];
    if (st)      m_busy = 1'b1;
    else if (dn) m_busy = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0; calc_start = 1'b0; calc_done = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 8'h0; wr_data = 32'h0; rd_addr = 8'h0;
    calc_start = 1'b0; calc_done = 1'b0; msi_en = 1'b0;
    m_stat = 0; m_arm = 0; m_busy = 0; m_intx = 0; m_msi = 0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R10");
    @(negedge clk); rst_n = 1'b1;

    // single-bit sets and clears in both modes
    for (int me = 0; me < 2; me++) begin
      for (int b = 0; b < 32; b++) begin
        step(me ? "R5" : "R3", 1'b1, 8'h60, 32'h1 << b, 1'b0, 1'b0, me[0]);
        step(me ? "R5" : "R1", 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, me[0]);
        step(me ? "R6" : "R4", 1'b1, 8'h64, 32'h1 << b, 1'b0, 1'b0, me[0]);
      end
      // accumulate, then partial and full clears
      step("R1", 1'b1, 8'h60, 32'hA5A5_0000, 1'b0, 1'b0, me[0]);
      step("R1", 1'b1, 8'h60, 32'h0000_5A5A, 1'b0, 1'b0, me[0]);
      step("R1", 1'b1, 8'h60, 32'h0, 1'b0, 1'b0, me[0]);
      step("R2", 1'b1, 8'h64, 32'hFFFF_0000, 1'b0, 1'b0, me[0]);
      step(me ? "R6" : "R4", 1'b1, 8'h64, 32'h0000_FFFF, 1'b0, 1'b0, me[0]);
      step(me ? "R6" : "R4", 1'b1, 8'h64, 32'h0, 1'b0, 1'b0, me[0]);
    end

    // mode switch while level is high: clears in message mode leave it high
    step("R3", 1'b1, 8'h60, 32'h10, 1'b0, 1'b0, 1'b0);
    step("R6", 1'b1, 8'h64, 32'h10, 1'b0, 1'b0, 1'b1);
    step("R4", 1'b1, 8'h64, 32'h0, 1'b0, 1'b0, 1'b0);

    // control register and completion source
    step("R7", 1'b1, 8'h20, 32'hFFFF_FF7F, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0);
    step("R8", 1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 8'h64, 32'h1, 1'b0, 1'b0, 1'b0);
    step("R8", 1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1);
    step("R8", 1'b1, 8'h20, 32'h0, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 1'b0);

    // completion set and clear in the same cycle
    for (int me = 0; me < 2; me++) begin
      step("R9", 1'b1, 8'h20, 32'h80, 1'b0, 1'b0, me[0]);
      step("R9", 1'b1, 8'h60, 32'h0000_0F00, 1'b0, 1'b0, me[0]);
      step("R9", 1'b1, 8'h64, 32'h0000_0100, 1'b0, 1'b1, me[0]);
      step("R9", 1'b1, 8'h64, 32'h0000_0E01, 1'b0, 1'b1, me[0]);
      step("R9", 1'b1, 8'h64, 32'hFFFF_FFFF, 1'b0, 1'b0, me[0]);
    end

    // writes to the status offset are ignored
    step("R11", 1'b1, 8'h60, 32'h3, 1'b0, 1'b0, 1'b0);
    step("R11", 1'b1, 8'h24, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    step("R11", 1'b1, 8'h24, 32'h0, 1'b0, 1'b0, 1'b0);

    // pseudo-random mix
    lfsr = 32'hC0DE_1234;
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:1])
        3'd0, 3'd1: a = 8'h60;
        3'd2, 3'd3: a = 8'h64;
        3'd4:       a = 8'h20;
        3'd5:       a = 8'h24;
        default:    a = 8'h44;
      endcase
      step("R9", lfsr[0], a, {lfsr[31:12], 8'h0, lfsr[11:8]} ^ (32'h1 << lfsr[20:16]),
           lfsr[5] & lfsr[6], lfsr[7], lfsr[9] & lfsr[10]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule